// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a peripheral clock into the 16x-oversampling tick that a UART transmitter and receiver use for bit timing. It chains two dividers. A fractional prescaler drops a fraction of the input clock cycles. An integer counter then divides the cycles that are left by a 16-bit divisor. The baud rate is the tick rate divided by 16. The prescaler makes the overall divide ratio non-integer, so a designer can get close to a standard baud rate from an awkward clock frequency.

The divisor arrives as a high byte and a low byte on plain input pins. The fractional settings live in a 32-bit register that is written and read through a simple register port. That register holds an add value in bits 3:0 and a multiplier in bits 7:4. The add value is how many extra cycles to swallow for every multiplier-many counted cycles.

New divisor and fractional values take effect only when the integer counter reloads. A write in the middle of a tick period therefore never produces a shortened or stretched tick. There is no data stream in this block, so every pin is a plain control or status signal.

Top module: `frac_baud_gen`

## Requirements
- R1: With divisor N = 256*hi + lo and fractional settings add A and multiplier M (valid when 1 <= M <= 15, 0 <= A <= 14 and A < M), the number of clock cycles spanned by K consecutive tick intervals is within one cycle of K*N*(M+A)/M.
- R2: While reset is held, `tick_o` is low and the fractional register reads 32'h0000_0010 (add 0, multiplier 1).
- R3: When the add field is 0, the fractional stage swallows no cycles, and ticks are exactly N clock cycles apart.
- R4: A divisor of 0 behaves as a divisor of 1.
- R5: A register write stores bits 3:0 as the add field and bits 7:4 as the multiplier. On the next cycle, `fdr_rdata_o[7:0]` returns those 8 bits.
- R6: Bits 31:8 of the fractional register always read as zero. Writing ones to them has no effect.
- R7: `tick_o` is a single-cycle pulse. With an effective divisor of 2 or more, it is never high on two consecutive cycles.
- R8: A change to the divisor or the fractional register takes effect only at the next counter reload. The tick interval in progress keeps its old length.
- R9: With valid settings, the fractional stage never swallows two consecutive cycles. At divisor 1, `tick_o` is never low on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_hi_i | input | 8 | High byte of the integer divisor |
| div_lo_i | input | 8 | Low byte of the integer divisor |
| fdr_wr_i | input | 1 | Write strobe for the fractional register |
| fdr_wdata_i | input | 32 | Write data: add in bits 3:0, multiplier in bits 7:4 |
| fdr_rdata_o | output | 32 | Read data of the fractional register, reserved bits zero |
| tick_o | output | 1 | One-cycle 16x-oversampling tick |

## Verification
The bench measures the span of a fixed number of tick intervals for several divisor and fraction pairs. These include the largest legal add value against multiplier 15 and a divisor above 255.
- A design with the multiplier and add fields swapped would miss that span by many cycles.
- A design with the high and low bytes swapped would miss it by a whole factor.

Divisor zero is exercised. A design that handles it by counting through all 16 bits would show a tick interval of 65536 cycles instead of 1. A divisor is changed ten cycles into a 100-cycle period. A design that adopts the new value at once would cut that period short. A register write with every reserved bit set is read back, which exposes any reserved bits that are stored. Finally, the pattern of swallowed cycles is inspected for back-to-back drops, which an accumulator that wraps wrongly would produce.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int FRAC_W = 4;

  // Packed so that mul lands in bits 7:4 and add in bits 3:0
  typedef struct packed {
    logic [FRAC_W-1:0] mul;
    logic [FRAC_W-1:0] add;
  } frac_cfg_t;

  localparam int CFG_W = $bits(frac_cfg_t);

  localparam frac_cfg_t FRAC_RESET = '{mul: FRAC_W'(1), add: FRAC_W'(0)};
endpackage

// File: rtl/baud_frac_reg.sv
module baud_frac_reg
  import baud_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output frac_cfg_t        cfg,
  output logic [REG_W-1:0] rdata
);
  frac_cfg_t cfg_q;

  // Only the defined field bits are stored; reserved bits have no flops
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= FRAC_RESET;
    else if (wr_en) cfg_q <= frac_cfg_t'(wdata[CFG_W-1:0]);
  end

  assign cfg   = cfg_q;
  assign rdata = REG_W'(cfg_q);

  // R5
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0]));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc
  import baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  frac_cfg_t cfg_in,
  output logic      en
);
  frac_cfg_t         act_q;
  logic [FRAC_W-1:0] acc_q;
  logic              skip_q;
  logic [FRAC_W:0]   sum;
  logic              wrap;

  assign sum  = {1'b0, acc_q} + {1'b0, act_q.add};
  assign wrap = sum >= {1'b0, act_q.mul};
  assign en   = !skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= FRAC_RESET;
      acc_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        acc_q  <= wrap ? FRAC_W'(sum - {1'b0, act_q.mul}) : FRAC_W'(sum);
        skip_q <= wrap;
      end
      if (load && cfg_in != act_q) begin
        act_q <= cfg_in;
        acc_q <= '0;
      end
    end
  end

  // R9
  no_double_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> en);

  // R1
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.mul != '0 && act_q.add < act_q.mul) |-> acc_q < act_q.mul);
endmodule

// File: rtl/baud_int_div.sv
module baud_int_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick,
  output logic             reload
);
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] div_act_q;
  logic [DIV_W-1:0] cnt_q;
  logic             loaded_q;
  logic             tick_q;
  logic             hit;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign hit     = loaded_q && en && cnt_q == '0;
  assign reload  = !loaded_q || hit;
  assign tick    = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      div_act_q <= DIV_W'(1);
      loaded_q  <= 1'b0;
      tick_q    <= 1'b0;
    end else begin
      tick_q <= hit;
      if (reload) begin
        cnt_q     <= div_eff - DIV_W'(1);
        div_act_q <= div_eff;
        loaded_q  <= 1'b1;
      end else if (en) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end

  // R7
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div_act_q > DIV_W'(1)) |=> !tick_q);

  // R8
  hold_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(div_act_q));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> cnt_q < div_act_q);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic              fdr_wr_i,
  input  logic [REG_W-1:0]  fdr_wdata_i,
  output logic [REG_W-1:0]  fdr_rdata_o,
  output logic              tick_o
);
  localparam int DIV_W = 2 * BYTE_W;

  frac_cfg_t cfg;
  logic      en;
  logic      reload;

  baud_frac_reg #(.REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (fdr_wr_i),
    .wdata (fdr_wdata_i),
    .cfg   (cfg),
    .rdata (fdr_rdata_o)
  );

  baud_phase_acc u_frac (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (reload),
    .cfg_in (cfg),
    .en     (en)
  );

  baud_int_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .divisor ({div_hi_i, div_lo_i}),
    .tick    (tick_o),
    .reload  (reload)
  );

  // R2
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !tick_o);
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_hi = 8'd0;
  logic [7:0]  div_lo = 8'd3;
  logic        fdr_wr = 1'b0;
  logic [31:0] fdr_wdata = '0;
  logic [31:0] fdr_rdata;
  logic        tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_hi_i    (div_hi),
    .div_lo_i    (div_lo),
    .fdr_wr_i    (fdr_wr),
    .fdr_wdata_i (fdr_wdata),
    .fdr_rdata_o (fdr_rdata),
    .tick_o      (tick)
  );

  // {div_hi, div_lo, fractional byte (mul 7:4, add 3:0), intervals K}
  localparam logic [31:0] VECS [8] = '{
    32'h00_01_10_32, 32'h00_04_10_14, 32'h00_03_52_0A, 32'h00_0A_F7_09,
    32'h01_00_21_04, 32'h00_07_FE_0F, 32'h00_00_10_14, 32'h00_02_43_10
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_fdr(input logic [31:0] d);
    @(negedge clk);
    fdr_wr = 1'b1;
    fdr_wdata = d;
    @(negedge clk);
    fdr_wr = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  // Cycles from one sampled tick to the k-th following tick
  task automatic span(input int k, output int c);
    c = 0;
    wait_tick();
    for (int i = 0; i < k; i++) begin
      do begin @(negedge clk); c++; end while (!tick);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c, n, m, a, k, lhs, rhs, d, prev, dbl, t;
    logic [7:0] f;
    // R2: reset state
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R2 tick in reset", tick, 0);
    check(fdr_rdata == 32'h10, "R2 register reset", fdr_rdata, 32'h10);
    rst_n = 1'b1;

    // R3: add 0 gives exact divisor spacing
    for (int i = 0; i < 3; i++) begin
      span(1, c);
      check(c == 3, "R3 exact interval", c, 3);
    end

    // Table walk: R1 ratio and R5 readback, R4 for divisor zero
    foreach (VECS[i]) begin
      div_hi = VECS[i][31:24];
      div_lo = VECS[i][23:16];
      f = VECS[i][15:8];
      k = int'(VECS[i][7:0]);
      wr_fdr({24'h0, f});
      check(fdr_rdata == {24'h0, f}, "R5 readback", fdr_rdata, f);
      wait_tick();
      wait_tick();
      n = 256 * int'(div_hi) + int'(div_lo);
      if (n == 0) n = 1;
      m = int'(f[7:4]);
      a = int'(f[3:0]);
      span(k, c);
      lhs = c * m;
      rhs = k * n * (m + a);
      d = lhs - rhs;
      if (d < 0) d = -d;
      if (VECS[i][31:16] == 16'h0)
        check(c == k, "R4 divisor zero", c, k);
      else
        check(d <= m, "R1 tick span", c, rhs / m);
    end

    // R6: reserved bits read zero after writing ones
    wr_fdr(32'hFFFF_FF43);
    check(fdr_rdata == 32'h43, "R6 reserved bits", fdr_rdata, 32'h43);

    // R7: single-cycle pulse at divisor 2
    div_hi = 8'd0; div_lo = 8'd2;
    wr_fdr(32'h10);
    wait_tick(); wait_tick();
    prev = 1; dbl = 0; t = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick && prev == 1) dbl++;
      if (tick) t++;
      prev = tick ? 1 : 0;
    end
    check(dbl == 0, "R7 back-to-back ticks", dbl, 0);
    check(t == 50, "R7 tick count", t, 50);

    // R8: divisor change mid-period does not cut the period
    div_lo = 8'd100;
    wait_tick(); wait_tick();
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 10) div_lo = 8'd5;
    end while (!tick);
    check(c == 100, "R8 old period kept", c, 100);
    span(0, c);
    c = 0;
    do begin @(negedge clk); c++; end while (!tick);
    check(c == 5, "R8 new period adopted", c, 5);

    // R9: no two consecutive swallowed cycles at divisor 1, mul 15 add 14
    div_lo = 8'd1;
    wr_fdr(32'hFE);
    wait_tick(); wait_tick();
    prev = 1; dbl = 0; t = 0;
    for (int i = 0; i < 290; i++) begin
      @(negedge clk);
      if (!tick && prev == 0) dbl++;
      if (tick) t++;
      prev = tick ? 1 : 0;
    end
    check(dbl == 0, "R9 double swallow", dbl, 0);
    check(t >= 149 && t <= 151, "R9 tick count", t, 150);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule